// File: doc/BRIEF.md
# Latched Time-of-Day and Day Counter Registers

The block keeps a running clock made of seconds, minutes, hours and a 9-bit day count. It sits behind a small host register port. A free-running base tick is divided by a sub-second prescaler, and every full second the live counters advance through the seconds, minutes, hours and days cascade. The host never reads the live counters directly. It reads a frozen snapshot. The snapshot is refreshed only when the host writes the byte $00 and then the byte $01 to a latch-control strobe, so a multi-byte read is always coherent while time keeps running.

Register index $0C packs the ninth day bit, a halt control that stops the clock, and a sticky overflow flag that is raised when the day count wraps. Writes through the register port load the live counters directly. Software is expected to set halt first.

Top module: `rtc_snap_top`

## Requirements
- R1: After reset all live and snapshot counters are 0, halt and overflow are clear, the latch sequence is disarmed, and every index reads 0.
- R2: Each group of TICKS_PER_SEC base-tick pulses advances seconds by one. Seconds (index $08) and minutes ($09) run 0-59 and hours ($0A) runs 0-23. Each field wraps to 0 and carries into the next one.
- R3: An hours wrap increments a 9-bit day count. Its low eight bits read at index $0B and its bit 8 reads at bit 0 of index $0C.
- R4: When the day count wraps from 511 to 0, bit 7 of index $0C becomes 1. It stays 1 through further counting until a write to $0C puts 0 in bit 7.
- R5: While bit 6 of index $0C (halt) is 1, neither the counters nor the prescaler advance. Clearing halt resumes counting.
- R6: Reads return the snapshot. The snapshot copies the live counters only on a latch event and otherwise holds its value.
- R7: A latch event occurs when a latch write of $01 arrives and the previous latch write was $00. Any other latch value disarms the sequence. A $01 without a preceding $00 has no effect.
- R8: A register write to indexes $08-$0C loads the live field and restarts the prescaler, so the next advance comes a full TICKS_PER_SEC ticks later.
- R9: Bits 5:1 of index $0C read 0. Bits above the field width of seconds (6 bits), minutes (6 bits) and hours (5 bits) read 0.
- R10: Read data is registered. It takes the selected snapshot value in the cycle after a read strobe, and an index outside $08-$0C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse from the time base |
| latchWr | input | 1 | Latch-control write strobe |
| latchData | input | 8 | Latch-control write value |
| regIdx | input | 4 | Register index, $8-$C |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write value |
| regRd | input | 1 | Register read strobe |
| rdData | output | 8 | Registered snapshot read data |

## Verification
A wrong live counter stays hidden until the next latch event. At that point every field of the snapshot shows it one cycle after a read. The bench therefore latches often during a long counting sweep, and an off-by-one in a wrap limit shows at the first latch after the boundary. A fault in the prescaler or the latch arming shows as a snapshot that is one second early, one second late, or not refreshed, on the very next read.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int DAY_W  = 9;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;

  localparam logic [3:0] IDX_SEC   = 4'h8;
  localparam logic [3:0] IDX_MIN   = 4'h9;
  localparam logic [3:0] IDX_HR    = 4'hA;
  localparam logic [3:0] IDX_DAYLO = 4'hB;
  localparam logic [3:0] IDX_DAYHI = 4'hC;

  localparam int HALT_BIT  = 6;
  localparam int CARRY_BIT = 7;

  typedef struct packed {
    logic adv;
    logic doLatch;
    logic wrSec;
    logic wrMin;
    logic wrHr;
    logic wrDayLo;
    logic wrDayHi;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
  import rtc_snap_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseTick,
  input  logic        latchWr,
  input  logic [7:0]  latchData,
  input  logic [3:0]  regIdx,
  input  logic        regWr,
  input  logic        haltLive,
  output rtcStrobes_t strb
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] preCnt;
  logic          armed;
  logic          anyWr;
  logic          tickDone;

  always_comb begin
    strb = '0;
    strb.wrSec   = regWr && (regIdx == IDX_SEC);
    strb.wrMin   = regWr && (regIdx == IDX_MIN);
    strb.wrHr    = regWr && (regIdx == IDX_HR);
    strb.wrDayLo = regWr && (regIdx == IDX_DAYLO);
    strb.wrDayHi = regWr && (regIdx == IDX_DAYHI);
    anyWr    = strb.wrSec | strb.wrMin | strb.wrHr | strb.wrDayLo | strb.wrDayHi;
    tickDone = baseTick && (preCnt == PRE_LAST);
    strb.adv     = tickDone && !haltLive && !anyWr;
    strb.doLatch = latchWr && (latchData == 8'h01) && armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      armed  <= 1'b0;
    end else begin
      if (anyWr)
        preCnt <= '0;
      else if (baseTick && !haltLive)
        preCnt <= tickDone ? '0 : preCnt + 1'b1;
      if (latchWr)
        armed <= (latchData == 8'h00);
    end
  end

  // R8: any counter write restarts the prescaler
  assert_pre_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regIdx >= IDX_SEC && regIdx <= IDX_DAYHI) |=> (preCnt == '0));
  // R7: a latch event consumes the arming
  assert_latch_disarm_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLatch |=> !armed);
  // R5: halt freezes the prescaler
  assert_pre_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    (haltLive && !regWr) |=> $stable(preCnt));
endmodule

// File: rtl/rtc_snap_dp.sv
module rtc_snap_dp
  import rtc_snap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rtcStrobes_t strb,
  input  logic [7:0]  regWrData,
  input  logic [3:0]  regIdx,
  input  logic        regRd,
  output logic        haltLive,
  output logic [7:0]  rdData
);
  logic [SEC_W-1:0] secLive, secSnap;
  logic [MIN_W-1:0] minLive, minSnap;
  logic [HR_W-1:0]  hrLive,  hrSnap;
  logic [DAY_W-1:0] dayLive, daySnap;
  logic             carryLive, carrySnap, haltSnap;

  logic secWrap, minWrap, hrWrap, dayWrap;
  logic [7:0] rdNext;

  always_comb begin
    secWrap = secLive >= SEC_W'(SEC_LAST);
    minWrap = minLive >= MIN_W'(MIN_LAST);
    hrWrap  = hrLive  >= HR_W'(HR_LAST);
    dayWrap = &dayLive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secLive   <= '0;
      minLive   <= '0;
      hrLive    <= '0;
      dayLive   <= '0;
      haltLive  <= 1'b0;
      carryLive <= 1'b0;
    end else begin
      if (strb.adv) begin
        secLive <= secWrap ? '0 : secLive + 1'b1;
        if (secWrap) begin
          minLive <= minWrap ? '0 : minLive + 1'b1;
          if (minWrap) begin
            hrLive <= hrWrap ? '0 : hrLive + 1'b1;
            if (hrWrap) begin
              dayLive <= dayLive + 1'b1;
              if (dayWrap) carryLive <= 1'b1;
            end
          end
        end
      end
      if (strb.wrSec)   secLive <= regWrData[SEC_W-1:0];
      if (strb.wrMin)   minLive <= regWrData[MIN_W-1:0];
      if (strb.wrHr)    hrLive  <= regWrData[HR_W-1:0];
      if (strb.wrDayLo) dayLive[7:0] <= regWrData;
      if (strb.wrDayHi) begin
        dayLive[8] <= regWrData[0];
        haltLive   <= regWrData[HALT_BIT];
        carryLive  <= regWrData[CARRY_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secSnap   <= '0;
      minSnap   <= '0;
      hrSnap    <= '0;
      daySnap   <= '0;
      haltSnap  <= 1'b0;
      carrySnap <= 1'b0;
    end else if (strb.doLatch) begin
      secSnap   <= secLive;
      minSnap   <= minLive;
      hrSnap    <= hrLive;
      daySnap   <= dayLive;
      haltSnap  <= haltLive;
      carrySnap <= carryLive;
    end
  end

  always_comb begin
    unique case (regIdx)
      IDX_SEC:   rdNext = 8'(secSnap);
      IDX_MIN:   rdNext = 8'(minSnap);
      IDX_HR:    rdNext = 8'(hrSnap);
      IDX_DAYLO: rdNext = daySnap[7:0];
      IDX_DAYHI: rdNext = {carrySnap, haltSnap, 5'b0, daySnap[8]};
      default:   rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 8'h00;
    else if (regRd) rdData <= rdNext;
  end

  // R2: seconds wrap to zero at the top of the range
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && secLive == SEC_W'(SEC_LAST)) |=> (secLive == '0));
  // R4: overflow flag is sticky unless index $0C is written
  assert_carry_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (carryLive && !strb.wrDayHi) |=> carryLive);
  // R4: full rollover raises the flag
  assert_carry_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && secWrap && minWrap && hrWrap && dayWrap) |=> carryLive);
  // R5: halted clock with no writes keeps its counters
  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    (haltLive && !(strb.wrSec | strb.wrMin | strb.wrHr | strb.wrDayLo | strb.wrDayHi))
      |=> ($stable(secLive) && $stable(minLive) && $stable(hrLive) && $stable(dayLive)));
  // R6: snapshot only moves on a latch event
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doLatch |=> ($stable(secSnap) && $stable(minSnap) && $stable(hrSnap) && $stable(daySnap)));
  // R2: seconds never leave 0-59 unless loaded out of range
  assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (secLive <= SEC_W'(SEC_LAST) && !strb.wrSec) |=> (secLive <= SEC_W'(SEC_LAST)));
endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
  import rtc_snap_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       latchWr,
  input  logic [7:0] latchData,
  input  logic [3:0] regIdx,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  input  logic       regRd,
  output logic [7:0] rdData
);
  rtcStrobes_t strb;
  logic        haltLive;

  rtc_snap_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) uCtrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .latchWr(latchWr),
    .latchData(latchData), .regIdx(regIdx), .regWr(regWr),
    .haltLive(haltLive), .strb(strb)
  );

  rtc_snap_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regIdx(regIdx), .regRd(regRd), .haltLive(haltLive), .rdData(rdData)
  );

  // R10: read data only changes after a read strobe
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> $stable(rdData));
endmodule

// File: tb/rtc_snap_top_test.sv
module rtc_snap_top_test;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseTick = 1'b0;
  logic latchWr = 1'b0;
  logic [7:0] latchData = 8'h00;
  logic [3:0] regIdx = 4'h0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic regRd = 1'b0;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rtc_snap_top #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .latchWr(latchWr),
    .latchData(latchData), .regIdx(regIdx), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .rdData(rdData)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) baseTick = 1'b1;
    @(negedge clk) baseTick = 1'b0;
  endtask

  task automatic seconds(input int n);
    for (int i = 0; i < n * TPS; i++) tick();
  endtask

  task automatic latchByte(input logic [7:0] v);
    @(negedge clk) begin latchWr = 1'b1; latchData = v; end
    @(negedge clk) latchWr = 1'b0;
  endtask

  task automatic doLatch();
    latchByte(8'h00);
    latchByte(8'h01);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] v);
    @(negedge clk) begin regWr = 1'b1; regIdx = idx; regWrData = v; end
    @(negedge clk) regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] v);
    @(negedge clk) begin regRd = 1'b1; regIdx = idx; end
    @(negedge clk) begin regRd = 1'b0; v = rdData; end
  endtask

  task automatic expectTime(input int t, input string req);
    logic [7:0] v;
    rd(4'h8, v); check(v, 8'(t % 60), req);
    rd(4'h9, v); check(v, 8'((t / 60) % 60), req);
    rd(4'hA, v); check(v, 8'((t / 3600) % 24), req);
    rd(4'hB, v); check(v, 8'((t / 86400) % 256), req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    int t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on every index
    for (int i = 8; i <= 12; i++) begin
      rd(4'(i), v); check(v, 8'h00, "R1");
    end
    doLatch();
    expectTime(0, "R1");

    // R2/R3: counting sweep from reset, latched every 61 seconds
    t = 0;
    for (int k = 0; k < 60; k++) begin
      seconds(61); t += 61;
      doLatch();
      expectTime(t, "R2");
    end
    seconds(1); t += 1; doLatch(); expectTime(t, "R2");

    // R3: hour and day carry from a preset
    wr(4'h8, 8'd50); wr(4'h9, 8'd59); wr(4'hA, 8'd23); wr(4'hB, 8'h05); wr(4'hC, 8'h00);
    seconds(15);
    doLatch();
    rd(4'h8, v); check(v, 8'd5, "R3");
    rd(4'h9, v); check(v, 8'd0, "R3");
    rd(4'hA, v); check(v, 8'd0, "R3");
    rd(4'hB, v); check(v, 8'h06, "R3");
    // R3: day bit 8 carry from low byte
    wr(4'h8, 8'd59); wr(4'h9, 8'd59); wr(4'hA, 8'd23); wr(4'hB, 8'hFF); wr(4'hC, 8'h00);
    seconds(1); doLatch();
    rd(4'hB, v); check(v, 8'h00, "R3");
    rd(4'hC, v); check(v, 8'h01, "R3");

    // R4: overflow past 511 sets sticky flag
    wr(4'h8, 8'd59); wr(4'h9, 8'd59); wr(4'hA, 8'd23); wr(4'hB, 8'hFF); wr(4'hC, 8'h01);
    seconds(1); doLatch();
    rd(4'hC, v); check(v, 8'h80, "R4");
    rd(4'hB, v); check(v, 8'h00, "R4");
    rd(4'h8, v); check(v, 8'h00, "R4");
    seconds(3); doLatch();
    rd(4'hC, v); check(v, 8'h80, "R4");
    rd(4'h8, v); check(v, 8'd3, "R4");
    wr(4'hC, 8'h00); doLatch();
    rd(4'hC, v); check(v, 8'h00, "R4");

    // R9: unused bits of index $0C read 0
    wr(4'hC, 8'hFF); doLatch();
    rd(4'hC, v); check(v, 8'hC1, "R9");

    // R5: halted clock does not advance
    wr(4'h8, 8'd20); wr(4'h9, 8'd7); wr(4'hA, 8'd3); wr(4'hB, 8'd9); wr(4'hC, 8'h40);
    seconds(5); doLatch();
    rd(4'h8, v); check(v, 8'd20, "R5");
    rd(4'hC, v); check(v, 8'h40, "R5");
    wr(4'hC, 8'h00);
    seconds(2); doLatch();
    rd(4'h8, v); check(v, 8'd22, "R5");
    rd(4'h9, v); check(v, 8'd7, "R5");

    // R9: out-of-width seconds/minute/hour bits are dropped
    wr(4'h8, 8'hC5); wr(4'h9, 8'hC3); wr(4'hA, 8'hE2); doLatch();
    rd(4'h8, v); check(v, 8'h05, "R9");
    rd(4'h9, v); check(v, 8'h03, "R9");
    rd(4'hA, v); check(v, 8'h02, "R9");

    // R8: a write restarts the prescaler
    tick(); tick();
    wr(4'h8, 8'd10);
    for (int i = 0; i < TPS - 1; i++) tick();
    doLatch();
    rd(4'h8, v); check(v, 8'd10, "R8");
    tick(); doLatch();
    rd(4'h8, v); check(v, 8'd11, "R8");

    // R6: snapshot holds while live clock runs
    seconds(4);
    rd(4'h8, v); check(v, 8'd11, "R6");
    doLatch();
    rd(4'h8, v); check(v, 8'd15, "R6");

    // R7: interrupted sequence does not latch
    seconds(3);
    latchByte(8'h00); latchByte(8'h05); latchByte(8'h01);
    rd(4'h8, v); check(v, 8'd15, "R7");
    latchByte(8'h01);
    rd(4'h8, v); check(v, 8'd15, "R7");
    latchByte(8'h00); latchByte(8'h00); latchByte(8'h01);
    rd(4'h8, v); check(v, 8'd18, "R7");
    seconds(2);
    latchByte(8'h01);
    rd(4'h8, v); check(v, 8'd18, "R7");

    // R10: index outside the map reads 0; data holds without a read strobe
    rd(4'h3, v); check(v, 8'h00, "R10");
    rd(4'h8, v);
    @(negedge clk) regIdx = 4'hA;
    @(negedge clk) check(rdData, 8'd18, "R10");

    summary();
  end
endmodule